// File: doc/BRIEF.md
# Way-Partitioned Not-Recently-Used Victim Selector

This block holds the replacement state of an A-way set-associative cache that is shared by several cores and split among them at way granularity. Each line carries a single "recently touched" flag, and one rotating replacement pointer serves every set and every core. Each core owns a register of A permission bits. Bit w allows that core to evict from way w.

The cache controller presents one access per cycle. An access carries the set, the requesting core, whether it hit, and on a hit the way that hit. On a miss, the victim way is produced combinationally in the same cycle. The search starts at the pointer and walks forward, and only ways the core may evict from are considered. The replacement state is then updated on the next clock edge. Permission masks are rewritten at interval boundaries by whatever decides the allocation. That decision lies outside this block.

Each access is classified into one of four kinds: IDLE (no access), HIT, FILL (a miss with a usable mask) and FAULT (a miss by a core whose mask is all zeros). The transitions are as follows:
- Any kind may follow any other, according to the inputs of the cycle.
- HIT and FILL update the touched flags.
- Only FILL advances the pointer.
- FAULT and IDLE leave all replacement state unchanged.

Top module: `nru_part_victim`

## Requirements
- R1: Every HIT or FILL sets the touched flag of the accessed way (the hit way, or the chosen victim) in that set, from the next cycle on.
- R2: If, after setting the flag, every way in the requesting core's nonzero mask has its flag at 1, the flags of those owned ways are all cleared except the accessed way's. Flags of ways outside the mask are kept.
- R3: On a FILL, the victim is the first way met at offset 0,1,…,A-1 from the pointer (way index (ptr+k) mod A) whose mask bit is 1 and whose touched flag is 0.
- R4: If no way in the core's mask has a flag of 0, which can happen after other cores hit in those ways, the victim is the first way from the pointer whose mask bit is 1.
- R5: One pointer of log2(A) bits serves all sets and cores. It advances by exactly one (mod A) after each FILL and is unchanged on HIT, IDLE and FAULT. A must be a power of two.
- R6: A hit is accepted in any way regardless of the mask. During a HIT, victim_valid and mask_error are 0.
- R7: On a miss by a core whose mask is all zeros, mask_error is 1 and victim_valid is 0, and neither the flags nor the pointer change.
- R8: After reset, every core's mask is all ones. A mask write takes effect from the following cycle, so an access in the same cycle as the write still uses the old mask.
- R9: victim_valid, victim_way and mask_error are combinational in the inputs of the current cycle.
- R10: After reset, the pointer is 0 and all flags are 0, so the first miss of core 0 picks way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_set | input | log2(SETS) | Set index of the access |
| acc_core | input | log2(CORES) | Requesting core |
| acc_hit | input | 1 | 1 for hit, 0 for miss |
| acc_hit_way | input | log2(WAYS) | Way that hit (used when acc_hit is 1) |
| mask_we | input | 1 | Mask write strobe |
| mask_core | input | log2(CORES) | Core whose mask is written |
| mask_data | input | WAYS | New permission mask |
| victim_valid | output | 1 | A victim is selected this cycle |
| victim_way | output | log2(WAYS) | Selected victim way |
| mask_error | output | 1 | Miss by a core with an empty mask |

## Verification
A mask write and a miss by the same core can fall in the same cycle. The bench issues both together, then repeats the miss on the next cycle. The first victim must follow the old mask and the second must follow the new one (R8).

A second collision arises when one core's hits fill every way owned by another core, and the owner then misses (R4). The bench provokes this on purpose and checks the fallback way.

Expected victims throughout come from an arithmetic model of the flags, pointer and masks kept in the bench. The model is fed a long pseudo-random sweep of mixed hits, misses and mask rewrites.

// File: rtl/nru_part_pkg.sv
package nru_part_pkg;
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_HIT   = 2'd1,
        ACC_FILL  = 2'd2,
        ACC_FAULT = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/nru_rot_scan.sv
module nru_rot_scan #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  used,
    input  logic [WAYS-1:0]  mask,
    input  logic [WAY_W-1:0] ptr,
    output logic             found,
    output logic [WAY_W-1:0] way
);
    logic [WAYS-1:0]  avail;
    logic [WAYS-1:0]  cand;
    logic [WAY_W-1:0] idx;

    always_comb begin
        avail = mask & ~used;
        cand  = (avail != '0) ? avail : mask;
        found = (mask != '0);
        way   = '0;
        idx   = '0;
        // walk from the farthest offset back to the pointer; nearest wins
        for (int k = WAYS - 1; k >= 0; k--) begin
            idx = ptr + WAY_W'(k);
            if (cand[idx]) way = idx;
        end
    end
endmodule

// File: rtl/nru_used_store.sv
module nru_used_store #(
    parameter int WAYS = 4,
    parameter int SETS = 8,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set,
    output logic [WAYS-1:0]  used_rd,
    input  logic             we,
    input  logic [WAY_W-1:0] way,
    input  logic [WAYS-1:0]  mask
);
    logic [WAYS-1:0] used_q [SETS];
    logic [WAYS-1:0] touched;
    logic [WAYS-1:0] nxt;

    assign used_rd = used_q[set];

    always_comb begin
        touched = used_q[set] | (WAYS'(1) << way);
        if ((mask != '0) && ((touched & mask) == mask))
            nxt = (touched & ~mask) | (WAYS'(1) << way);
        else
            nxt = touched;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) used_q[s] <= '0;
        end else if (we) begin
            used_q[set] <= nxt;
        end
    end

    assert_flag_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> used_q[$past(set)][$past(way)]);

    assert_owned_not_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && mask != '0 && $countones(mask) > 1)
            |=> ((used_q[$past(set)] & $past(mask)) != $past(mask)));
endmodule

// File: rtl/nru_part_victim.sv
module nru_part_victim #(
    parameter int WAYS  = 4,
    parameter int SETS  = 8,
    parameter int CORES = 2,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int SET_W  = $clog2(SETS),
    localparam int CORE_W = (CORES > 1) ? $clog2(CORES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [SET_W-1:0]  acc_set,
    input  logic [CORE_W-1:0] acc_core,
    input  logic              acc_hit,
    input  logic [WAY_W-1:0]  acc_hit_way,
    input  logic              mask_we,
    input  logic [CORE_W-1:0] mask_core,
    input  logic [WAYS-1:0]   mask_data,
    output logic              victim_valid,
    output logic [WAY_W-1:0]  victim_way,
    output logic              mask_error
);
    import nru_part_pkg::*;

    logic [WAYS-1:0]  mask_q [CORES];
    logic [WAY_W-1:0] ptr_q;
    logic [WAYS-1:0]  cur_mask;
    logic [WAYS-1:0]  used_rd;
    logic             scan_found;
    logic [WAY_W-1:0] scan_way;
    acc_kind_e        kind;
    logic             upd_we;
    logic [WAY_W-1:0] upd_way;

    assign cur_mask = mask_q[acc_core];

    nru_rot_scan #(.WAYS(WAYS)) u_scan (
        .used  (used_rd),
        .mask  (cur_mask),
        .ptr   (ptr_q),
        .found (scan_found),
        .way   (scan_way)
    );

    nru_used_store #(.WAYS(WAYS), .SETS(SETS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (acc_set),
        .used_rd (used_rd),
        .we      (upd_we),
        .way     (upd_way),
        .mask    (cur_mask)
    );

    // access classification
    always_comb begin
        if (!acc_valid)      kind = ACC_IDLE;
        else if (acc_hit)    kind = ACC_HIT;
        else if (scan_found) kind = ACC_FILL;
        else                 kind = ACC_FAULT;
    end

    // outputs per kind
    always_comb begin
        victim_valid = 1'b0;
        victim_way   = '0;
        mask_error   = 1'b0;
        upd_we       = 1'b0;
        upd_way      = '0;
        unique case (kind)
            ACC_IDLE: ;
            ACC_HIT: begin
                upd_we  = 1'b1;
                upd_way = acc_hit_way;
            end
            ACC_FILL: begin
                victim_valid = 1'b1;
                victim_way   = scan_way;
                upd_we       = 1'b1;
                upd_way      = scan_way;
            end
            ACC_FAULT: mask_error = 1'b1;
            default: ;
        endcase
    end

    // pointer and masks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            for (int c = 0; c < CORES; c++) mask_q[c] <= '1;
        end else begin
            if (kind == ACC_FILL) ptr_q <= ptr_q + 1'b1;
            if (mask_we) mask_q[mask_core] <= mask_data;
        end
    end

    assert_err_no_victim_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mask_error |-> (!victim_valid && cur_mask == '0));

    assert_victim_in_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> cur_mask[victim_way]);

    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_hit && victim_valid) |=> (ptr_q == $past(ptr_q) + 1'b1));

    assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_hit && victim_valid) |=> $stable(ptr_q));

    assert_hit_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_hit) |-> (!victim_valid && !mask_error));

    assert_mask_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_q[$past(mask_core)] == $past(mask_data)));
endmodule

// File: tb/nru_part_victim_tb.sv
module nru_part_victim_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 4;
    localparam int S = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic [2:0] acc_set = '0;
    logic [0:0] acc_core = '0;
    logic       acc_hit = 1'b0;
    logic [1:0] acc_hit_way = '0;
    logic       mask_we = 1'b0;
    logic [0:0] mask_core = '0;
    logic [3:0] mask_data = '0;
    logic       victim_valid;
    logic [1:0] victim_way;
    logic       mask_error;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [3:0] used_m [S];
    logic [3:0] mask_m [2];
    int ptr_m = 0;
    int lcg = 12345;

    always #(CLK_PERIOD/2) clk = ~clk;

    nru_part_victim #(.WAYS(W), .SETS(S), .CORES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_core(acc_core), .acc_hit(acc_hit), .acc_hit_way(acc_hit_way),
        .mask_we(mask_we), .mask_core(mask_core), .mask_data(mask_data),
        .victim_valid(victim_valid), .victim_way(victim_way), .mask_error(mask_error)
    );

    function automatic int exp_victim(logic [3:0] m, logic [3:0] u, int p);
        for (int k = 0; k < W; k++) if (m[(p + k) % W] && !u[(p + k) % W]) return (p + k) % W;
        for (int k = 0; k < W; k++) if (m[(p + k) % W]) return (p + k) % W;
        return -1;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, sample combinational outputs, update model, pass posedge
    task automatic cyc(string tag, bit v, int core, int set, bit hit, int hway,
                       bit we, int wcore, logic [3:0] wdata);
        int ev;
        logic [3:0] m, nu;
        @(negedge clk);
        acc_valid = v; acc_core = core[0:0]; acc_set = set[2:0];
        acc_hit = hit; acc_hit_way = hway[1:0];
        mask_we = we; mask_core = wcore[0:0]; mask_data = wdata;
        #1;
        m = mask_m[core];
        if (v && !hit) begin
            ev = exp_victim(m, used_m[set], ptr_m);
            if (ev < 0) begin
                check({tag, " R7 err"}, int'(mask_error), 1);
                check({tag, " R7 valid"}, int'(victim_valid), 0);
            end else begin
                check({tag, " R9 valid"}, int'(victim_valid), 1);
                check({tag, " R3 way"}, int'(victim_way), ev);
                nu = used_m[set] | (4'b1 << ev);
                if ((nu & m) == m) nu = (nu & ~m) | (4'b1 << ev);
                used_m[set] = nu;
                ptr_m = (ptr_m + 1) % W;
            end
        end else if (v) begin
            check({tag, " R6 valid"}, int'(victim_valid), 0);
            check({tag, " R6 err"}, int'(mask_error), 0);
            nu = used_m[set] | (4'b1 << hway);
            if (m != 0 && (nu & m) == m) nu = (nu & ~m) | (4'b1 << hway);
            used_m[set] = nu;
        end else begin
            check({tag, " idle valid"}, int'(victim_valid), 0);
        end
        if (we) mask_m[wcore] = wdata;
        @(posedge clk);
    endtask

    function automatic int rnd();
        lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
        return lcg >>> 8;
    endfunction

    initial begin
        repeat (CLK_PERIOD * 0 + 150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < S; s++) used_m[s] = '0;
        mask_m[0] = 4'hF; mask_m[1] = 4'hF;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R10: reset state
        check("R10 idle valid", int'(victim_valid), 0);
        check("R10 idle err", int'(mask_error), 0);
        @(negedge clk); acc_valid = 1; acc_core = 0; acc_set = 0; acc_hit = 0; #1;
        check("R10 first victim", int'(victim_way), 0);
        acc_valid = 0;
        cyc("R10", 1, 0, 0, 0, 0, 0, 0, 0);
        // R1: a hit marks its way, so the next miss skips it
        cyc("R1 hit", 1, 0, 2, 1, 1, 0, 0, 0);
        cyc("R1 miss", 1, 0, 2, 0, 0, 0, 0, 0);
        // R2: core 1 owns ways 0,1; repeated fills clear and reuse
        cyc("R2 wr", 0, 0, 0, 0, 0, 1, 1, 4'b0011);
        for (int i = 0; i < 5; i++) cyc("R2 fill", 1, 1, 3, 0, 0, 0, 0, 0);
        // R6: core 1 hits outside its mask
        cyc("R6 hit", 1, 1, 3, 1, 3, 0, 0, 0);
        cyc("R6 miss", 1, 0, 3, 0, 0, 0, 0, 0);
        // R4: core 0 touches core 1's ways without clearing them
        cyc("R4 h0", 1, 0, 5, 1, 0, 0, 0, 0);
        cyc("R4 h1", 1, 0, 5, 1, 1, 0, 0, 0);
        cyc("R4 fallback", 1, 1, 5, 0, 0, 0, 0, 0);
        // R7: empty mask
        cyc("R7 wr", 0, 0, 0, 0, 0, 1, 1, 4'b0000);
        cyc("R7 fault", 1, 1, 4, 0, 0, 0, 0, 0);
        cyc("R7 after", 1, 0, 4, 0, 0, 0, 0, 0);
        // R8: write and miss of the same core in one cycle
        cyc("R8 same", 1, 0, 6, 0, 0, 1, 0, 4'b0100);
        cyc("R8 next", 1, 0, 6, 0, 0, 0, 0, 0);
        cyc("R8 next2", 1, 0, 6, 0, 0, 0, 0, 0);
        // R5 and R3: pseudo-random sweep
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = rnd();
            if (i % 97 == 0)
                cyc("R5 sweep wr", r[0], r[1], r[4:2], r[5], r[7:6], 1, r[8], 4'(r[12:9] | ((i % 5 == 0) ? 0 : 1)));
            else
                cyc("R5 sweep", (r[3:0] != 0), r[4], r[7:5], r[8], r[10:9], 0, 0, 0);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule